// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a watchdog timer with two stages. It does not count a timer down. It holds an absolute 64-bit deadline and compares it against a free-running system counter supplied from outside. When the deadline is first reached, the block raises a warning level that serves as an interrupt. It then moves the deadline one offset further on. If that second deadline also passes with no refresh, the block raises a reset request. The time from the last refresh to the reset request is therefore twice the offset.

Software uses a simple register port that has two frames. The control frame holds a status/enable word, a 32-bit stage length, the deadline as two 32-bit halves, and two identification words. The refresh frame holds a single refresh register: a write of any value to it restarts the sequence. A write to the status/enable word also restarts the sequence, so writing zero both stops the watchdog and clears it. The reset-request bit is sticky until the next refresh, so software can tell afterwards that the watchdog fired.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset, warn_irq and reset_req are 0, and the status word, the stage length and both deadline halves read 0.
- R2: A write of any data to refresh-frame offset 0x000 loads the deadline with sys_cnt + stage length and clears both stage flags. Writes to any other refresh-frame offset have no effect.
- R3: A write to control-frame offset 0x000 sets enable from data bit 0 and performs the same refresh as R2.
- R4: While enabled with the warning clear, a cycle in which sys_cnt >= deadline (unsigned) sets warn_irq from the next cycle and reloads the deadline with that sys_cnt + stage length.
- R5: While enabled with the warning set, a cycle in which sys_cnt >= deadline sets reset_req from the next cycle. reset_req and warn_irq then stay set until a refresh.
- R6: While enable is 0, no stage flag is ever set, whatever sys_cnt is.
- R7: The status word at control offset 0x000 reads bit 0 = enable, bit 1 = warning flag, bit 2 = reset flag, and zeros above.
- R8: The stage length is read and written at control offset 0x008. The deadline's low half is at 0x010 and its high half at 0x014. A write to the stage length or to the deadline does not refresh.
- R9: The deadline comparison covers all 64 bits, including a carry across the 32-bit halves.
- R10: Identification words read at offsets 0xFCC and 0xFD0 in both frames, with the values of parameters ID_A and ID_B.
- R11: A refresh in the same cycle as an expiry wins and leaves no flag set. In a cycle that writes the deadline, no expiry is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sys_cnt | input | 64 | Free-running system counter |
| warn_irq | output | 1 | First-stage warning / interrupt level |
| reset_req | output | 1 | Second-stage reset request level |

## Verification
The assertions take it that each bus access lasts a single cycle with one strobe, and that sys_cnt is a steady binary value. They do not assume the counter only moves forward, so jumps of the counter are legal stimulus. The bench drives sys_cnt only at the falling edge and holds it constant across each rising edge. This lets its arithmetic model predict the exact cycle in which each flag changes. The sweeps step the counter one tick at a time through both stages for several stage lengths. They also include jumps far past the deadline and a deadline that carries across the two 32-bit halves.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_AW = 12;

    // byte offsets inside the control frame
    localparam logic [REG_AW-1:0] A_STATUS = 12'h000;
    localparam logic [REG_AW-1:0] A_LENGTH = 12'h008;
    localparam logic [REG_AW-1:0] A_DL_LO  = 12'h010;
    localparam logic [REG_AW-1:0] A_DL_HI  = 12'h014;
    // identification words, both frames
    localparam logic [REG_AW-1:0] A_ID_A   = 12'hFCC;
    localparam logic [REG_AW-1:0] A_ID_B   = 12'hFD0;
    // refresh frame kick register
    localparam logic [REG_AW-1:0] A_KICK   = 12'h000;

    typedef enum logic {
        FR_CONTROL = 1'b0,
        FR_REFRESH = 1'b1
    } frame_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WARN  = 2'd1,
        ST_FIRED = 2'd2
    } stage_e;

    typedef struct packed {
        logic status_wr;
        logic refresh;
        logic length_wr;
        logic dl_lo_wr;
        logic dl_hi_wr;
    } strobe_t;

    // status word bits: enable, warning flag, reset flag
    function automatic logic [2:0] status_bits(input logic en, input stage_e st);
        return {st == ST_FIRED, st != ST_RUN, en};
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter logic [31:0] ID_A = 32'h0000_0001,
    parameter logic [31:0] ID_B = 32'h0000_0002
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_frame,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              en_q,
    input  stage_e            stage_q,
    input  logic [DATA_W-1:0] length_q,
    input  logic [CNT_W-1:0]  deadline_q,
    output strobe_t           stb,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - 3;

    logic wr_ctl, wr_ref, is_ctl;

    always_comb begin
        is_ctl = (frame_e'(bus_frame) == FR_CONTROL);
        wr_ctl = bus_sel && bus_we && is_ctl;
        wr_ref = bus_sel && bus_we && !is_ctl;

        stb.status_wr = wr_ctl && (bus_addr == A_STATUS);
        stb.length_wr = wr_ctl && (bus_addr == A_LENGTH);
        stb.dl_lo_wr  = wr_ctl && (bus_addr == A_DL_LO);
        stb.dl_hi_wr  = wr_ctl && (bus_addr == A_DL_HI);
        // a kick or any write of the status word restarts the sequence
        stb.refresh   = stb.status_wr || (wr_ref && (bus_addr == A_KICK));
    end

    always_comb begin
        rdata = '0;
        if (bus_addr == A_ID_A) begin
            rdata = DATA_W'(ID_A);
        end else if (bus_addr == A_ID_B) begin
            rdata = DATA_W'(ID_B);
        end else if (is_ctl) begin
            unique case (bus_addr)
                A_STATUS: rdata = {{PAD_W{1'b0}}, status_bits(en_q, stage_q)};
                A_LENGTH: rdata = length_q;
                A_DL_LO:  rdata = deadline_q[DATA_W-1:0];
                A_DL_HI:  rdata = deadline_q[CNT_W-1:DATA_W];
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_expiry_engine.sv
module wdt_expiry_engine
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  sys_cnt,
    output logic              en_q,
    output stage_e            stage_q,
    output logic [DATA_W-1:0] length_q,
    output logic [CNT_W-1:0]  deadline_q
);
    localparam int EXT_W = CNT_W - DATA_W;

    logic [CNT_W-1:0] next_deadline;
    logic             due;
    logic             dl_wr;

    always_comb begin
        next_deadline = sys_cnt + {{EXT_W{1'b0}}, length_q};
        due           = (sys_cnt >= deadline_q);
        dl_wr         = stb.dl_lo_wr || stb.dl_hi_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            stage_q    <= ST_RUN;
            length_q   <= '0;
            deadline_q <= '0;
        end else begin
            if (stb.length_wr) length_q <= wdata;
            if (stb.status_wr) en_q     <= wdata[0];

            if (stb.refresh) begin
                deadline_q <= next_deadline;
                stage_q    <= ST_RUN;
            end else if (stb.dl_lo_wr) begin
                deadline_q[DATA_W-1:0] <= wdata;
            end else if (stb.dl_hi_wr) begin
                deadline_q[CNT_W-1:DATA_W] <= wdata;
            end else if (en_q && due) begin
                unique case (stage_q)
                    ST_RUN: begin
                        stage_q    <= ST_WARN;
                        deadline_q <= next_deadline;
                    end
                    ST_WARN:  stage_q <= ST_FIRED;
                    default:  stage_q <= ST_FIRED;
                endcase
            end
        end
    end

    // R6: nothing fires while disabled
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> stage_q != ST_FIRED || $past(stage_q) == ST_FIRED);

    // R4: the warning only appears while enabled, with the deadline moved on
    a_r4_warn_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_RUN) ##1 (stage_q == ST_WARN) |-> $past(en_q));

    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_RUN && !stb.refresh && !dl_wr) ##1 (stage_q == ST_WARN)
        |-> deadline_q == $past(sys_cnt) + {{EXT_W{1'b0}}, $past(length_q)});

    // R5: reset only after a warning, and sticky until refreshed
    a_r5_fire_after_warn: assert property (@(posedge clk) disable iff (rst)
        (stage_q != ST_FIRED) ##1 (stage_q == ST_FIRED) |-> $past(stage_q) == ST_WARN);

    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_FIRED && !stb.refresh) |=> stage_q == ST_FIRED);

    // R2 / R11: refresh always clears both flags
    a_r2_refresh_clears: assert property (@(posedge clk) disable iff (rst)
        stb.refresh |=> stage_q == ST_RUN);

    // R8: stage length changes only by its own write
    a_r8_length_hold: assert property (@(posedge clk) disable iff (rst)
        !stb.length_wr |=> $stable(length_q));

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [31:0] ID_A = 32'h5744_0001,
    parameter logic [31:0] ID_B = 32'h0000_0A21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_frame,
    input  logic [11:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [2*DATA_W-1:0] sys_cnt,
    output logic              warn_irq,
    output logic              reset_req
);
    localparam int CNT_W = 2 * DATA_W;

    strobe_t           stb;
    logic              en_q;
    stage_e            stage_q;
    logic [DATA_W-1:0] length_q;
    logic [CNT_W-1:0]  deadline_q;

    wdt_bus_decode #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ID_A   (ID_A),
        .ID_B   (ID_B)
    ) u_decode (
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_frame  (bus_frame),
        .bus_addr   (bus_addr),
        .en_q       (en_q),
        .stage_q    (stage_q),
        .length_q   (length_q),
        .deadline_q (deadline_q),
        .stb        (stb),
        .rdata      (bus_rdata)
    );

    wdt_expiry_engine #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .wdata      (bus_wdata),
        .sys_cnt    (sys_cnt),
        .en_q       (en_q),
        .stage_q    (stage_q),
        .length_q   (length_q),
        .deadline_q (deadline_q)
    );

    always_comb begin
        warn_irq  = (stage_q != ST_RUN);
        reset_req = (stage_q == ST_FIRED);
    end

    // R5: a reset request always carries the warning with it
    a_r5_warn_with_reset: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> warn_irq);

endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_frame = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] sys_cnt = '0;
    logic        warn_irq;
    logic        reset_req;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic        m_en = 1'b0;
    logic [31:0] m_len = '0;
    logic [63:0] m_dl = '0;
    logic        m_warn = 1'b0;
    logic        m_fire = 1'b0;

    always #4 clk = ~clk;

    wdt_two_stage u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_cnt   (sys_cnt),
        .warn_irq  (warn_irq),
        .reset_req (reset_req)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // one clock with an optional write; model applies the same rules
    task automatic cyc(input logic wr, input logic frame, input logic [11:0] addr,
                       input logic [31:0] data);
        logic kick, st_wr, dl_wr;
        bus_sel = wr; bus_we = wr; bus_frame = frame; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        st_wr = wr && !frame && addr == 12'h000;
        kick  = st_wr || (wr && frame && addr == 12'h000);
        dl_wr = wr && !frame && (addr == 12'h010 || addr == 12'h014);
        if (kick) begin
            m_dl = sys_cnt + {32'h0, m_len}; m_warn = 0; m_fire = 0;
        end else if (dl_wr) begin
            if (addr == 12'h010) m_dl[31:0] = data; else m_dl[63:32] = data;
        end else if (m_en && sys_cnt >= m_dl) begin
            if (!m_warn) begin m_warn = 1; m_dl = sys_cnt + {32'h0, m_len}; end
            else m_fire = 1;
        end
        if (st_wr) m_en = data[0];
        if (wr && !frame && addr == 12'h008) m_len = data;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        chk("R4 warn_irq", {63'h0, warn_irq}, {63'h0, m_warn});
        chk("R5 reset_req", {63'h0, reset_req}, {63'h0, m_fire});
    endtask

    task automatic rd(input logic frame, input logic [11:0] addr, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_frame = frame; bus_addr = addr;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] d;
        rd(0, 12'h000, d); chk({tag, " R7 status"}, {32'h0, d}, {61'h0, m_fire, m_warn, m_en});
        rd(0, 12'h010, d); chk({tag, " R8 dl_lo"}, {32'h0, d}, {32'h0, m_dl[31:0]});
        rd(0, 12'h014, d); chk({tag, " R8 dl_hi"}, {32'h0, d}, {32'h0, m_dl[63:32]});
    endtask

    initial begin
        int cyc_n = 0;
        forever begin
            @(posedge clk);
            cyc_n++;
            if (cyc_n > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        int lens[5] = '{1, 2, 3, 5, 8};
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 warn", {63'h0, warn_irq}, 64'h0);
        chk("R1 reset", {63'h0, reset_req}, 64'h0);
        rd(0, 12'h008, d); chk("R1 length", {32'h0, d}, 64'h0);
        chk_regs("R1");

        // R10: identification words in both frames
        rd(0, 12'hFCC, d); chk("R10 id_a ctl", {32'h0, d}, 64'h5744_0001);
        rd(1, 12'hFCC, d); chk("R10 id_a ref", {32'h0, d}, 64'h5744_0001);
        rd(0, 12'hFD0, d); chk("R10 id_b ctl", {32'h0, d}, 64'h0000_0A21);
        rd(1, 12'hFD0, d); chk("R10 id_b ref", {32'h0, d}, 64'h0000_0A21);

        // R4 R5 R3: tick-by-tick sweep over several stage lengths
        foreach (lens[i]) begin
            sys_cnt = 64'd1000 * (i + 1);
            cyc(1, 0, 12'h008, lens[i]);
            rd(0, 12'h008, d); chk("R8 length", {32'h0, d}, {32'h0, lens[i]});
            cyc(1, 0, 12'h000, 32'h1);
            chk_regs("R3 armed");
            for (int k = 0; k < 2 * lens[i] + 3; k++) begin
                sys_cnt = sys_cnt + 1;
                cyc(0, 0, 12'h0, 32'h0);
            end
            chk_regs("R5 fired");
            // R5 sticky while the counter keeps moving
            sys_cnt = sys_cnt + 64'd50;
            cyc(0, 0, 12'h0, 32'h0);
        end

        // R2: a kick with arbitrary data clears the fired state
        cyc(1, 1, 12'h000, 32'hDEAD_BEEF);
        chk_regs("R2 kick");

        // R4 then R2: a jump past the deadline, then a kick during the warning
        cyc(1, 0, 12'h008, 32'd10);
        sys_cnt = 64'd50_000;
        cyc(1, 1, 12'h000, 32'h0);
        sys_cnt = 64'd90_000;
        cyc(0, 0, 12'h0, 32'h0);
        chk_regs("R4 jump");
        cyc(0, 0, 12'h0, 32'h0);   // 90000 < 90010: no second stage yet
        cyc(1, 1, 12'h000, 32'h5);
        chk_regs("R2 warn cleared");

        // R2: refresh-frame write at another offset is ignored
        sys_cnt = 64'd90_009;
        cyc(1, 1, 12'h004, 32'h0);
        sys_cnt = 64'd90_010;
        cyc(0, 0, 12'h0, 32'h0);
        chk("R2 ignored offset warns", {63'h0, warn_irq}, 64'h1);

        // R11: refresh in the same cycle as an expiry wins
        cyc(1, 1, 12'h000, 32'h0);
        sys_cnt = 64'd90_020;
        cyc(1, 1, 12'h000, 32'h0);
        chk("R11 kick beats expiry", {63'h0, warn_irq}, 64'h0);

        // R8 R9: deadline written directly, carry across the halves
        cyc(1, 0, 12'h014, 32'h1);
        cyc(1, 0, 12'h010, 32'h0);
        sys_cnt = 64'h0000_0000_FFFF_FFFF;
        cyc(0, 0, 12'h0, 32'h0);
        chk("R9 below carry", {63'h0, warn_irq}, 64'h0);
        sys_cnt = 64'h0000_0001_0000_0000;
        cyc(0, 0, 12'h0, 32'h0);
        chk("R9 at carry", {63'h0, warn_irq}, 64'h1);
        chk_regs("R9 reload");

        // R11: a deadline write blocks the expiry that cycle
        sys_cnt = 64'h0000_0002_0000_0000;
        cyc(1, 0, 12'h010, 32'h7);
        chk("R11 dl write blocks", {63'h0, reset_req}, 64'h0);

        // R6: disable mid-interval, then run far past any deadline
        cyc(1, 0, 12'h000, 32'h1);
        sys_cnt = sys_cnt + 64'd4;
        cyc(0, 0, 12'h0, 32'h0);
        cyc(1, 0, 12'h000, 32'h0);
        for (int k = 0; k < 6; k++) begin
            sys_cnt = sys_cnt + 64'd1000;
            cyc(0, 0, 12'h0, 32'h0);
        end
        chk("R6 off warn", {63'h0, warn_irq}, 64'h0);
        chk_regs("R6 off");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule